// File: doc/BRIEF.md
# Increment-and-skip executor

This block carries out two single-word instructions of a small 8-bit controller core. Both read one byte from the data memory, add one to it (wrapping at 256) and send the result either to the working register W or back to the same memory location. The first variant then skips the following instruction when the wrapped result is zero. The second skips it when the result is nonzero. Neither variant touches any status flag.

Execution follows a four-phase instruction cycle: decode, operand read, increment and write-back. The instruction word arrives on a valid/ready stream that is ready only in the first phase. Producer rules: hold `ins_valid` and `ins_word` stable until the first-phase edge. A cycle whose first phase sees no valid word is idle and consumes nothing. A taken skip discards the next one or two words of the stream: two when `follow_dbl` is high during the write-back phase. While discarded words pass through, `flush` is high and all memory and W activity is suppressed. The address is built from the bank register or from the access-bank split. In extended mode, low access addresses are flagged for indexed offset addressing, which a neighbouring adder completes.

Top module: `incskip_exec`

## Requirements
- R1: After reset the phase output `qph` steps 0,1,2,3,0,... (0 = decode, 1 = read, 2 = increment, 3 = write) every clock. `ins_ready` is high only when `qph` = 0.
- R2: A word accepted with bits 15:10 = 001111 (skip if zero) or 010010 (skip if nonzero) executes. Bit 9 is d, bit 8 is a and bits 7:0 are f. Any other word produces no read, no write, no W change and no skip.
- R3: With a = 1, `rf_addr` = {bsr, f}. With a = 0, f < 0x60 and `ext_en` = 0, `rf_addr` = {0x0, f}. With a = 0 and f ≥ 0x60, `rf_addr` = {0xF, f}. With a = 0, `ext_en` = 1 and f < 0x60, `rf_idx` = 1 and `rf_addr` = {0x0, f}. In every other case `rf_idx` = 0.
- R4: An executing instruction raises `rf_rd` in phase 1 only, and `rf_rdata` is taken at the end of phase 1.
- R5: The result is (operand + 1) mod 256. If d = 1, `rf_wr` is high in phase 3 with `rf_wdata` = result. If d = 0, there is no write and `w` takes the result after phase 3. Otherwise `w` never changes.
- R6: The skip is taken when the result is 0x00 for the skip-if-zero variant, or when it is not 0x00 for the skip-if-nonzero variant.
- R7: A taken skip discards the next accepted word, or the next two if `follow_dbl` is high in phase 3. `flush` stays high until they are consumed. Discarded words cause no read, no write and no W change, even if they are matching opcodes.
- R8: `pc_adv` pulses in phase 3 of every cycle that accepted a word, discarded words included.
- R9: Synchronous active-high `rst` clears `w` and any pending skip, and puts `qph` at 0.
- R10: An idle cycle (no valid word in phase 0) gives no `pc_adv` and leaves a pending skip count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Word accepted this cycle (phase 0) |
| ins_word | input | 16 | Instruction word |
| bsr | input | 4 | Bank-select value |
| ext_en | input | 1 | Extended addressing mode enable |
| follow_dbl | input | 1 | Following instruction is two words (read in phase 3) |
| rf_addr | output | 12 | Data-memory address |
| rf_idx | output | 1 | Address needs indexed offset completion |
| rf_rd | output | 1 | Data-memory read strobe |
| rf_rdata | input | 8 | Read data |
| rf_wr | output | 1 | Data-memory write strobe |
| rf_wdata | output | 8 | Write data |
| w | output | 8 | Working register |
| qph | output | 2 | Current phase |
| pc_adv | output | 1 | Program counter advance pulse |
| flush | output | 1 | Skip pending / discarding words |

## Verification
The bench targets the wrap from 0xFF to 0x00. A design that tested the unwrapped sum would reverse both skip decisions there. It targets the two-word follower, where a fixed one-word flush would let the second word execute. It sends matching opcodes as discarded words and an idle gap inside a pending flush: a weak design would write memory from a flushed word, or count the idle cycle as consumed. It also probes the access-bank split on both sides of 0x60 with extended mode on and off, where an off-by-one would land in the wrong bank.

// File: rtl/isk_pkg.sv
package isk_pkg;
  localparam int INSN_W = 16;
  localparam logic [5:0] OPC_SKZ  = 6'b001111;
  localparam logic [5:0] OPC_SKNZ = 6'b010010;
  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_e;
endpackage

// File: rtl/isk_phase.sv
module isk_phase
  import isk_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e ph
);
  always_ff @(posedge clk) begin
    if (rst) ph <= PH_Q1;
    else     ph <= phase_e'(ph + 2'd1);
  end

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ph == phase_e'($past(ph) + 2'd1));
endmodule

// File: rtl/isk_addr.sv
module isk_addr #(
  parameter int FW = 8,
  parameter int BW = 4,
  parameter logic [FW-1:0] SPLIT = 8'h60
) (
  input  logic [FW-1:0]    f,
  input  logic             a,
  input  logic             ext_en,
  input  logic [BW-1:0]    bsr,
  output logic [BW+FW-1:0] addr,
  output logic             idx
);
  logic low_half;
  assign low_half = (f < SPLIT);

  always_comb begin
    idx  = 1'b0;
    addr = {{BW{1'b0}}, f};
    if (a) begin
      addr = {bsr, f};
    end else if (low_half) begin
      idx = ext_en;
    end else begin
      addr = {{BW{1'b1}}, f};
    end
  end
endmodule

// File: rtl/isk_skipctl.sv
module isk_skipctl #(
  parameter int MAXS = 2,
  localparam int CW = $clog2(MAXS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dbl,
  input  logic consume,
  output logic pending
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= dbl ? CW'(2) : CW'(1);
    else if (consume && pending) cnt <= cnt - CW'(1);
  end

  assign pending = (cnt != '0);

  p_cnt_max_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(MAXS));
  p_consume_r7: assert property (@(posedge clk) disable iff (rst)
    consume |-> pending);
  p_noload_pend_r7: assert property (@(posedge clk) disable iff (rst)
    load |-> !pending);
endmodule

// File: rtl/incskip_exec.sv
module incskip_exec
  import isk_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = 8,
  parameter int BW = 4,
  parameter logic [FW-1:0] ACC_SPLIT = 8'h60,
  localparam int AW = BW + FW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [INSN_W-1:0] ins_word,
  input  logic [BW-1:0]     bsr,
  input  logic              ext_en,
  input  logic              follow_dbl,
  output logic [AW-1:0]     rf_addr,
  output logic              rf_idx,
  output logic              rf_rd,
  input  logic [DW-1:0]     rf_rdata,
  output logic              rf_wr,
  output logic [DW-1:0]     rf_wdata,
  output logic [DW-1:0]     w,
  output logic [1:0]        qph,
  output logic              pc_adv,
  output logic              flush
);
  phase_e            ph;
  logic              took, act, nop, pending;
  logic [INSN_W-1:0] ir;
  logic [DW-1:0]     opnd, res;
  logic              take_word, match, is_nz, dsel, take_skip, consume;

  isk_phase u_phase (.clk(clk), .rst(rst), .ph(ph));

  isk_addr #(.FW(FW), .BW(BW), .SPLIT(ACC_SPLIT)) u_addr (
    .f(ir[FW-1:0]), .a(ir[8]), .ext_en(ext_en), .bsr(bsr),
    .addr(rf_addr), .idx(rf_idx)
  );

  assign ins_ready = (ph == PH_Q1);
  assign take_word = ins_ready && ins_valid;
  assign match     = (ins_word[INSN_W-1 -: 6] == OPC_SKZ) ||
                     (ins_word[INSN_W-1 -: 6] == OPC_SKNZ);
  assign is_nz     = (ir[INSN_W-1 -: 6] == OPC_SKNZ);
  assign dsel      = ir[9];

  always_ff @(posedge clk) begin
    if (rst) begin
      took <= 1'b0;
      act  <= 1'b0;
      nop  <= 1'b0;
      ir   <= '0;
      opnd <= '0;
      res  <= '0;
      w    <= '0;
    end else begin
      if (ph == PH_Q1) begin
        took <= take_word;
        act  <= take_word && match && !pending;
        nop  <= take_word && pending;
        if (take_word) ir <= ins_word;
      end
      if (ph == PH_Q2 && act) opnd <= rf_rdata;
      if (ph == PH_Q3 && act) res  <= opnd + DW'(1);
      if (ph == PH_Q4 && act && !dsel) w <= res;
    end
  end

  assign take_skip = act && (ph == PH_Q4) && (is_nz ? (res != '0) : (res == '0));
  assign consume   = nop && (ph == PH_Q4);

  isk_skipctl #(.MAXS(2)) u_skip (
    .clk(clk), .rst(rst), .load(take_skip), .dbl(follow_dbl),
    .consume(consume), .pending(pending)
  );

  assign rf_rd    = act && (ph == PH_Q2);
  assign rf_wr    = act && (ph == PH_Q4) && dsel;
  assign rf_wdata = res;
  assign pc_adv   = took && (ph == PH_Q4);
  assign flush    = pending;
  assign qph      = ph;

  p_ready_once_r1: assert property (@(posedge clk) disable iff (rst)
    ins_ready |=> !ins_ready);
  p_rd_phase_r4: assert property (@(posedge clk) disable iff (rst)
    rf_rd |-> qph == 2'd1);
  p_wr_phase_r5: assert property (@(posedge clk) disable iff (rst)
    rf_wr |-> qph == 2'd3);
  p_w_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (qph != 2'd3) |=> $stable(w));
  p_flush_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!rf_rd && !rf_wr));
  p_pc_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    pc_adv |=> !pc_adv);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (ins_ready && !ins_valid && flush) |=> flush);
endmodule

// File: tb/incskip_exec_bench.sv
`timescale 1ns/1ps
module incskip_exec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [15:0] ins_word = '0;
  logic [3:0]  bsr = '0;
  logic        ext_en = 1'b0;
  logic        follow_dbl = 1'b0;
  logic [11:0] rf_addr;
  logic        rf_idx, rf_rd, rf_wr, pc_adv, flush;
  logic [7:0]  rf_rdata = '0;
  logic [7:0]  rf_wdata, w;
  logic [1:0]  qph;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // reference model state
  logic [7:0] m_w = '0;
  int         m_skip = 0;

  always #4 clk = ~clk;

  incskip_exec u_incskip_exec (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .bsr(bsr), .ext_en(ext_en), .follow_dbl(follow_dbl),
    .rf_addr(rf_addr), .rf_idx(rf_idx), .rf_rd(rf_rd), .rf_rdata(rf_rdata),
    .rf_wr(rf_wr), .rf_wdata(rf_wdata), .w(w), .qph(qph),
    .pc_adv(pc_adv), .flush(flush)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit nz, input bit d, input bit a, input logic [7:0] f);
    return {(nz ? 6'b010010 : 6'b001111), d, a, f};
  endfunction

  // one full instruction cycle, entered at a falling edge in phase 0
  task automatic run_cyc(input bit v, input logic [15:0] wd, input bit dbl,
                         input logic [7:0] rd, input logic [3:0] b, input bit ext);
    bit         is_z, is_n, ex, d, a, sk;
    logic [7:0] f, r;
    logic [11:0] ea;
    bit         eidx;
    is_z = (wd[15:10] == 6'b001111);
    is_n = (wd[15:10] == 6'b010010);
    ex   = v && (is_z || is_n) && (m_skip == 0);
    d = wd[9]; a = wd[8]; f = wd[7:0];
    r = rd + 8'd1;
    eidx = 1'b0;
    if (a) ea = {b, f};
    else if (f <= 8'h5F) begin ea = {4'h0, f}; eidx = ext; end
    else ea = {4'hF, f};
    // phase 0
    chk("R1 phase0", qph, 0);
    chk("R1 ready", ins_ready, 1);
    chk("R6/R7 flush", flush, (m_skip != 0));
    chk("R5 w", w, m_w);
    ins_valid = v; ins_word = wd; bsr = b; ext_en = ext;
    @(negedge clk);
    // phase 1
    chk("R1 phase1", qph, 1);
    chk("R1 notready", ins_ready, 0);
    chk("R2/R4/R7 rd", rf_rd, ex);
    if (ex) begin
      chk("R3 addr", rf_addr, ea);
      chk("R3 idx", rf_idx, eidx);
    end
    ins_valid = 1'b0;
    rf_rdata = rd;
    @(negedge clk);
    // phase 2
    chk("R4 rd off", rf_rd, 0);
    chk("R5 wr off", rf_wr, 0);
    rf_rdata = ~rd;
    @(negedge clk);
    // phase 3
    chk("R2/R5/R7 wr", rf_wr, ex && d);
    if (ex && d) chk("R5 wdata", rf_wdata, r);
    chk("R8/R10 pc", pc_adv, v);
    follow_dbl = dbl;
    @(negedge clk);
    follow_dbl = 1'b0;
    // model update
    if (ex) begin
      if (!d) m_w = r;
      sk = is_z ? (r == 8'h00) : (r != 8'h00);
      if (sk) m_skip = dbl ? 2 : 1;
    end else if (v && m_skip != 0) begin
      m_skip--;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 phase", qph, 0);
    chk("R9 w", w, 0);
    chk("R9 flush", flush, 0);
    // banked write-back, no skip
    run_cyc(1, mk(0, 1, 1, 8'h25), 0, 8'h10, 4'h3, 0);
    // skip-if-zero wraps 0xFF -> 0x00 into W, one-word skip
    run_cyc(1, mk(0, 0, 1, 8'h40), 0, 8'hFF, 4'h2, 0);
    run_cyc(1, mk(1, 1, 1, 8'h41), 0, 8'h05, 4'h2, 0); // discarded matching word
    // skip-if-zero to memory, two-word follower, idle gap inside flush
    run_cyc(1, mk(0, 1, 0, 8'h10), 1, 8'hFF, 4'h0, 0);
    run_cyc(0, 16'h0000, 0, 8'h00, 4'h0, 0);            // R10 idle
    run_cyc(1, mk(0, 0, 1, 8'h11), 0, 8'hFF, 4'h1, 0);  // discarded 1
    run_cyc(1, 16'h1234, 0, 8'h00, 4'h1, 0);            // discarded 2
    // skip-if-nonzero taken into W
    run_cyc(1, mk(1, 0, 1, 8'h80), 0, 8'h41, 4'h7, 0);
    run_cyc(1, 16'hFFFF, 0, 8'h00, 4'h7, 0);
    // skip-if-nonzero not taken on wrap
    run_cyc(1, mk(1, 1, 1, 8'h81), 0, 8'hFF, 4'h7, 0);
    // R3 access-bank split and extended mode
    run_cyc(1, mk(0, 1, 0, 8'h5F), 0, 8'h01, 4'h9, 0);
    run_cyc(1, mk(0, 1, 0, 8'h60), 0, 8'h02, 4'h9, 0);
    run_cyc(1, mk(0, 1, 0, 8'h5F), 0, 8'h03, 4'h9, 1);
    run_cyc(1, mk(0, 1, 0, 8'h60), 0, 8'h04, 4'h9, 1);
    // R2 other opcode: no effect
    run_cyc(1, 16'h2A5A, 0, 8'hFF, 4'h1, 0);
    run_cyc(1, mk(0, 0, 1, 8'h22), 0, 8'h7F, 4'h1, 0);
    chk("R2/R5 w after", w, m_w);
    // pending skip then mid-run reset
    run_cyc(1, mk(0, 0, 1, 8'h23), 1, 8'hFF, 4'h1, 0);
    chk("R7 pending", flush, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_w = '0; m_skip = 0;
    chk("R9 phase mid", qph, 0);
    chk("R9 w mid", w, 0);
    chk("R9 flush mid", flush, 0);
    run_cyc(1, mk(1, 0, 1, 8'h30), 0, 8'h00, 4'h4, 0);
    run_cyc(1, 16'h0000, 0, 8'h00, 4'h4, 0);
    chk("R5 w end", w, m_w);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule